// File: doc/BRIEF.md
# Two-Wire Serial Slave for a Byte Array

This block is the bus-facing half of a serial byte store. It watches the two open-drain lines of a two-wire bus with its own system clock, recognises start and stop conditions, decodes the header byte, and serves reads and writes on a 1024 x 8 array. The array lives outside the block. Write bytes go out to a separate page-write unit as single-cycle strobes that carry an address. Read data comes back through a combinational read port that is addressed by the block's internal address pointer. The data line is driven only as an output enable that pulls the line low.

The header byte carries four things: a fixed device-type code, a select field that is compared with a strap input, the top bits of the array address, and a direction bit. A write header is followed by a word-address byte, and then by any number of data bytes. A read header starts a stream from the address pointer. That stream keeps going for as long as the master acknowledges each byte. When the page-write unit reports that it is busy, the slave does not respond to its own address.

Top module: `twowire_mem_slave`

## Requirements
- R1: While reset is asserted and in the cycle after it, `sda_oe` and `wr_en` are low.
- R2: A start condition (SDA falls while SCL is high) restarts header decoding at any point, even mid-byte. A stop condition (SDA rises while SCL is high) ends the transfer and drops any partly received byte, so nothing is written.
- R3: The header is received MSB first. Bits 7:4 must equal 1010, bit 3 must equal `strap_i`, bits 2:1 are array address bits 9:8, and bit 0 selects read (1) or write (0). Any other header gets no acknowledge.
- R4: The slave pulls SDA low during the ninth clock after a matching header, and also after each word-address byte and each data byte of a write.
- R5: Each write data byte produces a single-cycle `wr_en` pulse. `wr_addr` is {header bits 2:1, word-address byte}, advanced as R6 describes, and `wr_data` is the byte.
- R6: Within one write, each data byte after the first goes to the next address in bits 3:0, which wrap modulo 16. Bits 9:4 stay fixed.
- R7: Read bytes are sent MSB first, and SDA is released in the ninth clock. An acknowledge from the master (SDA low) brings the next byte. A not-acknowledge leaves SDA released until the next start.
- R8: An internal pointer holds the last accessed address plus one, with the page rule of R6 applied on writes. A read header always reads from this pointer, and its bits 2:1 are ignored.
- R9: A write header with a word address, then a repeated start and a read header, reads from that word address.
- R10: Sequential reads step all 10 address bits, and address 1023 is followed by address 0.
- R11: While `busy_i` is high, a matching header gets no acknowledge, and the rest of the transaction has no effect.
- R12: `sda_oe` high means SDA is pulled low. `sda_oe` is never high while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 1 | Select value compared with header bit 3 |
| busy_i | input | 1 | Page-write unit busy; the slave stays off the bus |
| sda_oe | output | 1 | Pull SDA low when high |
| wr_en | output | 1 | Single-cycle write strobe toward the page-write unit |
| wr_addr | output | 10 | Array address of the write byte |
| wr_data | output | 8 | Write byte |
| rd_addr | output | 10 | Array address for the read port (the pointer) |
| rd_data | input | 8 | Array data at `rd_addr`, combinational |

## Verification
The cases that are hardest to reach from the ports are the interrupted transfers: a stop, or a repeated start, arriving partway through a byte, while the word address has already reset the pointer. The bench's bus master can send a chosen number of bits and then issue a start or a stop. It then reads the affected location back through the normal read path. This shows that no write happened and that the pointer holds the address it was loaded with. A busy window and a read stream that wraps past 1023 are driven the same way, and each is checked only through acknowledges and returned bytes.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_RD
   } tw_state_e;

   localparam int BYTE_W = 8;
   localparam int HDR_TYPE_W = 4;
endpackage

// File: rtl/tw_line_mon.sv
module tw_line_mon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tw_line_mon: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] scl_ff, sda_ff;
   logic         scl_q, sda_q;

   generate
      if (SYNC_STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[0], scl_i};
               sda_ff <= {sda_ff[0], sda_i};
            end
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[TOP-1:0], scl_i};
               sda_ff <= {sda_ff[TOP-1:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_ff[TOP];
         sda_q <= sda_ff[TOP];
      end
   end

   assign scl_s     = scl_ff[TOP];
   assign sda_s     = sda_ff[TOP];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_full,
   input  logic              inc_page,
   output logic [ADDR_W-1:0] cnt
);
   logic [ADDR_W-1:0] page_next;

   generate
      if (PAGE_W < 1) begin : g_bad_page
         $error("tw_addr_ctr: PAGE_W must be at least 1");
      end
      if (PAGE_W >= ADDR_W) begin : g_flat
         assign page_next = cnt + 1'b1;
      end else begin : g_paged
         logic [PAGE_W-1:0] low_inc;
         assign low_inc   = cnt[PAGE_W-1:0] + 1'b1;
         assign page_next = {cnt[ADDR_W-1:PAGE_W], low_inc};

         // R6: page step leaves the upper address bits alone
         assert_page_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            (inc_page && !load && !inc_full) |=>
               (cnt[ADDR_W-1:PAGE_W] == $past(cnt[ADDR_W-1:PAGE_W])));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= load_val;
      else if (inc_full) cnt <= cnt + 1'b1;
      else if (inc_page) cnt <= page_next;
   end

   // R10: full step from the last address lands on zero
   assert_wrap_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc_full && !load && (cnt == {ADDR_W{1'b1}})) |=> (cnt == '0));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
   import tw_pkg::*;
#(
   parameter int          ADDR_W      = 10,
   parameter int          PAGE_W      = 4,
   parameter int          SYNC_STAGES = 2,
   parameter logic [3:0]  DEV_TYPE    = 4'b1010,
   localparam int         HI_W        = ADDR_W - BYTE_W,
   localparam int         STRAP_W     = 3 - HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic              busy_i,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data
);
   generate
      if (ADDR_W < 9 || ADDR_W > 10) begin : g_bad_addr
         $error("twowire_mem_slave: ADDR_W must be 9 or 10");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   tw_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   tw_state_e         st;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] sreg, tx;
   logic [HI_W-1:0]   hi_q;
   logic              ack_q, rd_first;

   logic [BYTE_W-1:0] rx_byte;
   logic              byte_done, ack_clk, hdr_match;
   logic              ctr_load, ctr_inc_full, ctr_inc_page;
   logic [ADDR_W-1:0] ptr;
   logic [2:0]        tx_idx;

   always_comb begin
      rx_byte      = {sreg[BYTE_W-2:0], sda_s};
      byte_done    = scl_rise && (bitcnt == 4'd7) &&
                     (st == ST_DEV || st == ST_WADDR || st == ST_WDATA);
      ack_clk      = scl_rise && (bitcnt == 4'd8);
      hdr_match    = (rx_byte[7:4] == DEV_TYPE) &&
                     (rx_byte[3 -: STRAP_W] == strap_i) && !busy_i;
      ctr_load     = byte_done && (st == ST_WADDR);
      ctr_inc_page = byte_done && (st == ST_WDATA);
      ctr_inc_full = ack_clk && (st == ST_RD) && (rd_first || !sda_s);
      tx_idx       = 3'd7 - bitcnt[2:0];
   end

   tw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(ctr_load), .load_val({hi_q, rx_byte}),
      .inc_full(ctr_inc_full), .inc_page(ctr_inc_page),
      .cnt(ptr)
   );

   assign rd_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bitcnt   <= '0;
         sreg     <= '0;
         tx       <= '0;
         hi_q     <= '0;
         ack_q    <= 1'b0;
         rd_first <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st       <= ST_DEV;
            bitcnt   <= '0;
            ack_q    <= 1'b0;
            rd_first <= 1'b0;
            sda_oe   <= 1'b0;
         end else if (stop_det) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            ack_q    <= 1'b0;
            rd_first <= 1'b0;
            sda_oe   <= 1'b0;
         end else begin
            if (scl_rise && st != ST_IDLE) begin
               if (bitcnt != 4'd8) begin
                  sreg   <= rx_byte;
                  bitcnt <= bitcnt + 4'd1;
               end else begin
                  bitcnt <= '0;
               end
            end

            if (byte_done) begin
               unique case (st)
                  ST_DEV: begin
                     if (hdr_match) begin
                        ack_q    <= 1'b1;
                        hi_q     <= rx_byte[HI_W:1];
                        rd_first <= rx_byte[0];
                        st       <= rx_byte[0] ? ST_RD : ST_WADDR;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
                  ST_WADDR: begin
                     ack_q <= 1'b1;
                     st    <= ST_WDATA;
                  end
                  ST_WDATA: begin
                     ack_q   <= 1'b1;
                     wr_en   <= 1'b1;
                     wr_addr <= ptr;
                     wr_data <= rx_byte;
                  end
                  default: ;
               endcase
            end

            if (ack_clk) begin
               ack_q <= 1'b0;
               if (st == ST_RD) begin
                  if (rd_first || !sda_s) begin
                     tx       <= rd_data;
                     rd_first <= 1'b0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end

            if (scl_fall) begin
               if (bitcnt == 4'd8)     sda_oe <= ack_q;
               else if (st == ST_RD)   sda_oe <= ~tx[tx_idx];
               else                    sda_oe <= 1'b0;
            end
         end
      end
   end

   // R2: a start always re-arms header decoding with the line released
   assert_start_rearm_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == ST_DEV && bitcnt == 4'd0 && !sda_oe));

   // R2: a stop always leaves the slave idle
   assert_stop_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == ST_IDLE));

   // R12: nothing is pulled low while idle
   assert_idle_quiet_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R5: write strobes only follow a data byte of a write
   assert_wr_from_data_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(st) == ST_WDATA));

   // R11: a header seen while busy sends the slave back to idle
   assert_busy_reject_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && st == ST_DEV && busy_i) |=> (st == ST_IDLE));
endmodule

// File: tb/test_twowire_mem_slave.sv
`timescale 1ns/1ps
module test_twowire_mem_slave;
   localparam time TCLK = 4ns;
   localparam time Q    = 40ns;
   localparam int  WATCHDOG_CYC = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       strap = 1'b0, busy = 1'b0;
   logic       sda_oe, wr_en;
   logic [9:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   wire        sda_line = sda_m & ~sda_oe;

   always #(TCLK/2) clk = ~clk;

   twowire_mem_slave i_twowire_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .strap_i(strap), .busy_i(busy), .sda_oe(sda_oe),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   logic [7:0] model_mem [1024];
   logic [7:0] exp_mem   [1024];
   int         wr_pulses = 0;
   logic [9:0] last_wa;
   logic [7:0] last_wd;

   assign rd_data = model_mem[rd_addr];
   always @(posedge clk) if (wr_en) begin
      model_mem[wr_addr] <= wr_data;
      wr_pulses <= wr_pulses + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
   end

   int  n_run = 0, n_fail = 0;
   bit  done = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1; #Q; scl_m = 1; #Q; sda_m = 0; #Q; scl_m = 0; #Q;
   endtask

   task automatic bus_stop();
      sda_m = 0; #Q; scl_m = 1; #Q; sda_m = 1; #(4*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; #Q; scl_m = 1; #(2*Q); scl_m = 0; #Q;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic nack);
      send_bits(b, 8);
      sda_m = 1; #Q; scl_m = 1; #Q; nack = sda_line; #Q; scl_m = 0; #Q;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         #Q; scl_m = 1; #Q; b[i] = sda_line; #Q; scl_m = 0;
      end
      #Q; sda_m = mack ? 1'b0 : 1'b1; #Q; scl_m = 1; #(2*Q); scl_m = 0; sda_m = 1; #Q;
   endtask

   function automatic logic [7:0] hdr(input logic [1:0] hi, input bit rd);
      return {4'b1010, strap, hi, rd};
   endfunction

   // write n bytes starting at a, values first+k, with page wrap of bits 3:0
   task automatic write_seq(input logic [9:0] a, input int n, input logic [7:0] first);
      logic nk;
      bus_start();
      send_byte(hdr(a[9:8], 0), nk); check("R4 header ack", nk, 0);
      send_byte(a[7:0], nk);         check("R4 word ack", nk, 0);
      for (int k = 0; k < n; k++) begin
         logic [9:0] ea;
         ea = {a[9:4], 4'(a[3:0] + k)};
         send_byte(8'(first + k), nk); check("R4 data ack", nk, 0);
         exp_mem[ea] = 8'(first + k);
      end
      bus_stop();
   endtask

   task automatic read_stream(input int n, input logic [9:0] a, input string tag);
      logic [7:0] got;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, got);
         check(tag, got, exp_mem[10'(a + k)]);
      end
   endtask

   task automatic rand_read(input logic [9:0] a, input int n, input string tag);
      logic nk;
      bus_start();
      send_byte(hdr(a[9:8], 0), nk); check("R9 dummy header ack", nk, 0);
      send_byte(a[7:0], nk);         check("R9 word ack", nk, 0);
      bus_start();
      send_byte(hdr(2'b00, 1), nk);  check("R9 read header ack", nk, 0);
      read_stream(n, a, tag);
      bus_stop();
   endtask

   task automatic cur_read(input logic [9:0] ea, input logic [1:0] hi, input string tag);
      logic nk;
      bus_start();
      send_byte(hdr(hi, 1), nk); check("R8 header ack", nk, 0);
      read_stream(1, ea, tag);
      bus_stop();
   endtask

   // op 0 = write byte, op 1 = random read expecting data
   localparam int NV = 8;
   localparam logic [19:0] VEC [NV] = '{
      {2'd0, 10'h005, 8'h3C}, {2'd0, 10'h2A7, 8'hC5}, {2'd0, 10'h100, 8'h01},
      {2'd1, 10'h005, 8'h3C}, {2'd1, 10'h2A7, 8'hC5}, {2'd1, 10'h100, 8'h01},
      {2'd0, 10'h3FF, 8'h99}, {2'd1, 10'h3FF, 8'h99}
   };

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic       nk;
      logic [7:0] got;
      int         wp0;
      for (int i = 0; i < 1024; i++) begin
         model_mem[i] = 8'(i * 7 + 3);
         exp_mem[i]   = 8'(i * 7 + 3);
      end
      repeat (5) @(posedge clk);
      #1;
      check("R1 sda_oe in reset", sda_oe, 0);
      check("R1 wr_en in reset", wr_en, 0);
      rst_n = 1;
      @(posedge clk); #1;
      check("R1 sda_oe after reset", sda_oe, 0);
      check("R12 released when idle", sda_oe, 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         logic [1:0] op; logic [9:0] a; logic [7:0] d;
         {op, a, d} = VEC[v];
         if (op == 2'd0) begin
            wp0 = wr_pulses;
            write_seq(a, 1, d);
            check("R5 one strobe per byte", wr_pulses - wp0, 1);
            check("R5 strobe address", last_wa, a);
            check("R5 strobe data", last_wd, d);
         end else begin
            rand_read(a, 1, "R3 R9 readback");
            check("R9 table expect", exp_mem[a], d);
         end
      end

      // page wrap: 0x01E, 0x01F, then 0x010
      wp0 = wr_pulses;
      write_seq(10'h01E, 3, 8'hA0);
      check("R6 wrapped strobe address", last_wa, 10'h010);
      check("R5 three strobes", wr_pulses - wp0, 3);
      cur_read(10'h011, 2'b00, "R8 pointer after page write");
      rand_read(10'h010, 1, "R6 wrapped byte");
      check("R6 wrapped value", exp_mem[10'h010], 8'hA2);

      // sequential wrap through 1023
      rand_read(10'h3FE, 3, "R10 R7 sequential wrap");
      cur_read(10'h001, 2'b11, "R8 pointer after wrap, header bits ignored");

      // header mismatches
      bus_start(); send_byte(8'b1010_1000, nk); check("R3 strap mismatch nack", nk, 1); bus_stop();
      bus_start(); send_byte(8'b1011_0000, nk); check("R3 type mismatch nack", nk, 1); bus_stop();

      // busy
      busy = 1;
      wp0 = wr_pulses;
      bus_start();
      send_byte(hdr(2'b00, 0), nk); check("R11 busy header nack", nk, 1);
      send_byte(8'h60, nk);         check("R11 busy word nack", nk, 1);
      send_byte(8'hEE, nk);
      bus_stop();
      busy = 0;
      check("R11 no strobe while busy", wr_pulses - wp0, 0);
      rand_read(10'h060, 1, "R11 location unchanged");

      // stop in the middle of a data byte
      wp0 = wr_pulses;
      bus_start();
      send_byte(hdr(2'b00, 0), nk); send_byte(8'h40, nk);
      send_bits(8'h00, 4);
      bus_stop();
      check("R2 stop drops partial byte", wr_pulses - wp0, 0);
      rand_read(10'h040, 1, "R2 after stop abort");

      // repeated start in the middle of a data byte
      wp0 = wr_pulses;
      bus_start();
      send_byte(hdr(2'b00, 0), nk); send_byte(8'h50, nk);
      send_bits(8'hFF, 3);
      bus_start();
      send_byte(hdr(2'b00, 1), nk); check("R2 header after mid-byte start", nk, 0);
      recv_byte(0, got);
      check("R2 R8 read from loaded pointer", got, exp_mem[10'h050]);
      repeat (20) @(posedge clk);
      check("R7 released after nack", sda_oe, 0);
      bus_stop();
      check("R2 no write from aborted byte", wr_pulses - wp0, 0);

      // multi-byte read with acks
      rand_read(10'h2A6, 3, "R7 acked stream");
      #1;
      check("R12 idle release", sda_oe, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule